// File: doc/BRIEF.md
# Zero-Suppressed Channel Readout Sequencer

This block drives the readout of a small bank of channel data words once a readout path has been granted. A single start pulse launches a sequence whose shape is picked by a compression-mode bit sampled with the start. With compression off, the block walks the channels from zero upward and offers every channel as a data word. With compression on, it first makes a fixed-length pre-scan over all channels. During that scan it records in a small address memory the index of every channel whose compare result marks it as valid, and counts them. It then offers a header word carrying that count, followed only by the valid channels in ascending order.

The channel memory and the threshold compare are outside the block. The block presents a channel address. It receives that channel's data word and the compare carry for it, both combinationally. Each output word is held with a readout-enable flag until the downstream side acknowledges it. A one-cycle done pulse marks the end of every sequence. When a compressed scan finds nothing, that pulse comes without any word being offered.

Top module: `zs_readout_seq`

## Requirements
- R1: A start pulse seen while idle launches a sequence and latches the compression bit. A start pulse that arrives while a sequence is running has no effect on the words offered or on their order.
- R2: With compression off, readEnable rises on the third rising clock edge after the edge that samples start. The first word offered is channel 0, formatted as in R7.
- R3: With compression off, exactly NUM_CH data words are offered, for channels 0 to NUM_CH-1 in order. Each word advances on an acknowledge, and wordCount shows NUM_CH during the readout.
- R4: With compression on, the pre-scan takes 18 clock edges, counted from the edge that samples start: one edge to clear the counters, 16 edges that step the scan address over channels 0..15, and one final edge. readEnable or done appears on the 19th edge.
- R5: During the scan, a channel counts as valid when chanValid is high while chanAddr shows it. After the scan, wordCount equals the number of valid channels and never exceeds NUM_CH.
- R6: In compressed mode the first word offered is a header. Bit 16 is 1, bits 15:5 are 0, and bits 4:0 hold the valid-channel count.
- R7: A data word has bit 16 = 0, bits 15:12 = channel address and bits 11:0 = channel data. In compressed mode, after the header, only valid channels are offered, in ascending address order.
- R8: A compressed scan that finds no valid channel never raises readEnable. Instead it gives the done pulse on the 19th edge.
- R9: done is a single-cycle pulse. After a readout, it rises on the edge that consumes the acknowledge of the last word, and readEnable falls on that same edge.
- R10: While readEnable is high and no acknowledge is given, readWord stays unchanged.
- R11: After reset, readEnable and done are low and wordCount is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a sequence (honoured only while idle) |
| compress | input | 1 | Compression mode, sampled with start |
| chanData | input | 12 | Data word of the channel at chanAddr |
| chanValid | input | 1 | Compare carry of the channel at chanAddr |
| rdAck | input | 1 | Downstream acknowledge of the word offered |
| chanAddr | output | 4 | Channel address to the data memory |
| readWord | output | 17 | Word offered downstream (header or data) |
| readEnable | output | 1 | readWord is valid and waits for rdAck |
| wordCount | output | 5 | Number of words counted for the current sequence |
| done | output | 1 | One-cycle end-of-readout pulse |

## Verification
The bench goes after the edge counts of both modes. A design that gives a pulse too many or too few in the pre-scan raises readEnable on the wrong edge and fails the cycle-count checks. It covers scans with no valid channel, where a design that emitted a header anyway would offer a word with count zero instead of giving the done pulse. It also covers scans where only channel 0 or only channel 15 is valid, and scans where every channel is valid. A scan pointer or address-memory index that is off by one would drop or repeat the first or the last entry, and a count that wrapped would report 0 instead of 16. Starts injected during readout and random acknowledge delays expose designs that restart mid-sequence or change the word before it is accepted.

// File: rtl/zsr_pkg.sv
package zsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_LOAD,
    ST_SCAN,
    ST_FINAL,
    ST_READ
  } seqState_t;

  // Strobes from the sequencer control to the datapath
  typedef struct packed {
    logic initCnt;    // clear scan address, word count and read pointer
    logic loadFirst;  // uncompressed: capture channel 0 and step address
    logic scanStep;   // compressed: one scan slot
    logic emitHeader; // compressed: build header, arm word countdown
    logic nextWord;   // an acknowledge consumed a non-final word
    logic selMem;     // address channels through the address memory
    logic sparse;     // latched compression mode
  } dpCtrl_t;

endpackage

// File: rtl/zsr_ctrl.sv
module zsr_ctrl
  import zsr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    compress,
  input  logic    rdAck,
  input  logic    scanLast,
  input  logic    countZero,
  input  logic    lastWord,
  output dpCtrl_t ctl,
  output logic    readEnable,
  output logic    done
);

  seqState_t state, stateNext;
  logic      modeSparse;
  logic      rdEnNext, doneNext;

  always_comb begin
    stateNext = state;
    rdEnNext  = readEnable;
    doneNext  = 1'b0;
    ctl       = '0;
    ctl.sparse = modeSparse;
    ctl.selMem = modeSparse && (state == ST_READ);
    unique case (state)
      ST_IDLE: if (start) stateNext = ST_INIT;
      ST_INIT: begin
        ctl.initCnt = 1'b1;
        stateNext   = modeSparse ? ST_SCAN : ST_LOAD;
      end
      ST_LOAD: begin
        ctl.loadFirst = 1'b1;
        rdEnNext      = 1'b1;
        stateNext     = ST_READ;
      end
      ST_SCAN: begin
        ctl.scanStep = 1'b1;
        if (scanLast) stateNext = ST_FINAL;
      end
      ST_FINAL: begin
        ctl.emitHeader = 1'b1;
        if (countZero) begin
          doneNext  = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          rdEnNext  = 1'b1;
          stateNext = ST_READ;
        end
      end
      ST_READ: begin
        if (rdAck) begin
          if (lastWord) begin
            rdEnNext  = 1'b0;
            doneNext  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            ctl.nextWord = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      modeSparse <= 1'b0;
      readEnable <= 1'b0;
      done       <= 1'b0;
    end else begin
      state      <= stateNext;
      readEnable <= rdEnNext;
      done       <= doneNext;
      if (state == ST_IDLE && start) modeSparse <= compress;
    end
  end

endmodule

// File: rtl/zsr_datapath.sv
module zsr_datapath
  import zsr_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 12,
  localparam int ADDR_W = $clog2(NUM_CH),
  localparam int CNT_W  = ADDR_W + 1,
  localparam int OUT_W  = 1 + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] chanData,
  input  logic              chanValid,
  output logic [ADDR_W-1:0] chanAddr,
  output logic [OUT_W-1:0]  readWord,
  output logic [CNT_W-1:0]  wordCount,
  output logic              scanLast,
  output logic              countZero,
  output logic              lastWord
);

  logic [ADDR_W-1:0] addrCnt;
  logic [ADDR_W-1:0] readPtr;
  logic [CNT_W-1:0]  wordsLeft;
  logic [ADDR_W-1:0] addrMem [NUM_CH];

  assign chanAddr  = ctl.selMem ? addrMem[readPtr] : addrCnt;
  assign scanLast  = (addrCnt == ADDR_W'(NUM_CH - 1));
  assign countZero = (wordCount == '0);
  assign lastWord  = (wordsLeft == '0);

  // Valid-address list; written only during the scan, read only after it
  always_ff @(posedge clk) begin
    if (ctl.scanStep && chanValid)
      addrMem[wordCount[ADDR_W-1:0]] <= addrCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt   <= '0;
      readPtr   <= '0;
      wordCount <= '0;
      wordsLeft <= '0;
      readWord  <= '0;
    end else begin
      if (ctl.initCnt) begin
        addrCnt   <= '0;
        readPtr   <= '0;
        wordCount <= '0;
      end
      if (ctl.loadFirst) begin
        readWord  <= {1'b0, addrCnt, chanData};
        addrCnt   <= addrCnt + 1'b1;
        wordCount <= CNT_W'(NUM_CH);
        wordsLeft <= CNT_W'(NUM_CH - 1);
      end
      if (ctl.scanStep) begin
        addrCnt <= addrCnt + 1'b1;
        if (chanValid) wordCount <= wordCount + 1'b1;
      end
      if (ctl.emitHeader) begin
        readWord  <= {1'b1, {(OUT_W - 1 - CNT_W){1'b0}}, wordCount};
        wordsLeft <= wordCount;
        readPtr   <= '0;
      end
      if (ctl.nextWord) begin
        readWord  <= {1'b0, chanAddr, chanData};
        wordsLeft <= wordsLeft - 1'b1;
        if (ctl.sparse) readPtr <= readPtr + 1'b1;
        else            addrCnt <= addrCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/zs_readout_seq.sv
module zs_readout_seq
  import zsr_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 12,
  localparam int ADDR_W = $clog2(NUM_CH),
  localparam int CNT_W  = ADDR_W + 1,
  localparam int OUT_W  = 1 + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              compress,
  input  logic [DATA_W-1:0] chanData,
  input  logic              chanValid,
  input  logic              rdAck,
  output logic [ADDR_W-1:0] chanAddr,
  output logic [OUT_W-1:0]  readWord,
  output logic              readEnable,
  output logic [CNT_W-1:0]  wordCount,
  output logic              done
);

  dpCtrl_t ctl;
  logic    scanLast, countZero, lastWord;

  zsr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .compress   (compress),
    .rdAck      (rdAck),
    .scanLast   (scanLast),
    .countZero  (countZero),
    .lastWord   (lastWord),
    .ctl        (ctl),
    .readEnable (readEnable),
    .done       (done)
  );

  zsr_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .chanData  (chanData),
    .chanValid (chanValid),
    .chanAddr  (chanAddr),
    .readWord  (readWord),
    .wordCount (wordCount),
    .scanLast  (scanLast),
    .countZero (countZero),
    .lastWord  (lastWord)
  );

endmodule

// File: rtl/zsr_checker.sv
module zsr_checker #(
  parameter int NUM_CH = 16,
  parameter int OUT_W  = 17,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdAck,
  input logic [OUT_W-1:0] readWord,
  input logic             readEnable,
  input logic [CNT_W-1:0] wordCount,
  input logic             done
);

  // R10: an offered word holds until acknowledged
  p_word_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    readEnable && !rdAck |=> readEnable && $stable(readWord));

  // R9: done lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: the enable falls only together with done
  p_enable_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readEnable) |-> done);

  // R9: done never coincides with a pending word
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !readEnable);

  // R6: a header word opens with the nonzero valid count
  p_header_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readEnable) && readWord[OUT_W-1] |->
      readWord[CNT_W-1:0] == wordCount && wordCount != '0);

  // R5: the count never exceeds the channel total
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    wordCount <= CNT_W'(NUM_CH));

endmodule

bind zs_readout_seq zsr_checker #(
  .NUM_CH(NUM_CH), .OUT_W(OUT_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdAck      (rdAck),
  .readWord   (readWord),
  .readEnable (readEnable),
  .wordCount  (wordCount),
  .done       (done)
);

// File: tb/tb_zs_readout_seq.sv
module tb_zs_readout_seq;

  localparam int NUM_CH = 16;
  localparam int DATA_W = 12;
  localparam int OUT_W  = 17;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              compress = 1'b0;
  logic              rdAck = 1'b0;
  logic [3:0]        chanAddr;
  logic [OUT_W-1:0]  readWord;
  logic              readEnable;
  logic [4:0]        wordCount;
  logic              done;
  logic [DATA_W-1:0] chanData;
  logic              chanValid;

  logic [DATA_W-1:0] memData [NUM_CH];
  logic [DATA_W-1:0] thresh = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // Channel memory and threshold compare modelled outside the block
  assign chanData  = memData[chanAddr];
  assign chanValid = memData[chanAddr] > thresh;

  zs_readout_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .compress(compress),
    .chanData(chanData), .chanValid(chanValid), .rdAck(rdAck),
    .chanAddr(chanAddr), .readWord(readWord), .readEnable(readEnable),
    .wordCount(wordCount), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [OUT_W-1:0] dataWord(input int ch);
    return {1'b0, 4'(ch), memData[ch]};
  endfunction

  function automatic int validCount();
    int n = 0;
    for (int c = 0; c < NUM_CH; c++) if (memData[c] > thresh) n++;
    return n;
  endfunction

  task automatic runSeq(input bit sparse, input int maxDelay, input bit injectStart);
    logic [OUT_W-1:0] expWords [NUM_CH + 1];
    int nExp = 0;
    int nValid = validCount();
    int cyc = 0;
    if (sparse) begin
      expWords[nExp++] = {1'b1, 11'b0, 5'(nValid)};
      for (int c = 0; c < NUM_CH; c++)
        if (memData[c] > thresh) expWords[nExp++] = dataWord(c);
    end else begin
      for (int c = 0; c < NUM_CH; c++) expWords[nExp++] = dataWord(c);
    end
    @(negedge clk);
    start = 1'b1; compress = sparse;
    @(negedge clk);
    start = 1'b0; compress = $urandom_range(0, 1);
    cyc = 1;
    while (!readEnable && !done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    if (sparse) begin
      check(cyc == 19, "R4 scan length", cyc, 19);
      check(int'(wordCount) == nValid, "R5 valid count", wordCount, nValid);
      if (nValid == 0) begin
        check(done && !readEnable, "R8 empty scan ends", {readEnable, done}, 1);
        @(negedge clk);
        check(!done && !readEnable, "R8 no word after empty scan", {readEnable, done}, 0);
        return;
      end
    end else begin
      check(cyc == 3, "R2 enable edge", cyc, 3);
      check(int'(wordCount) == NUM_CH, "R3 word count", wordCount, NUM_CH);
    end
    for (int i = 0; i < nExp; i++) begin
      int dly = $urandom_range(0, maxDelay);
      for (int d = 0; d < dly; d++) @(negedge clk);
      check(readEnable, "R10 enable held", readEnable, 1);
      if (i == 0 && sparse)
        check(readWord == expWords[0], "R6 header", readWord, expWords[0]);
      else if (i == 0)
        check(readWord == expWords[0], "R2 first word", readWord, expWords[0]);
      else if (sparse)
        check(readWord == expWords[i], "R7 sparse word", readWord, expWords[i]);
      else
        check(readWord == expWords[i], "R3 ordered word", readWord, expWords[i]);
      rdAck = 1'b1;
      if (injectStart) begin start = 1'b1; compress = ~sparse; end  // R1 busy start
      @(negedge clk);
      rdAck = 1'b0; start = 1'b0;
      if (i == nExp - 1) begin
        check(done && !readEnable, "R9 done with last ack", {readEnable, done}, 1);
        @(negedge clk);
        check(!done, "R9 done single pulse", done, 0);
      end else begin
        check(!done, "R9 no early done", done, 0);
      end
    end
    if (injectStart) check(!readEnable, "R1 busy start ignored", readEnable, 0);
  endtask

  task automatic fillRandom(input int bias);
    for (int c = 0; c < NUM_CH; c++) memData[c] = DATA_W'($urandom_range(0, 4095));
    thresh = DATA_W'(bias);
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0x1 expected=0x0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NUM_CH; c++) memData[c] = '0;
    repeat (3) @(negedge clk);
    check(!readEnable && !done && wordCount == 0, "R11 reset state",
          {readEnable, done, wordCount}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!readEnable && !done, "R11 after release", {readEnable, done}, 0);

    // Uncompressed order
    fillRandom(2000);
    runSeq(1'b0, 2, 1'b0);
    // Empty compressed scan
    fillRandom(4095);
    runSeq(1'b1, 1, 1'b0);
    // Only channel 0 valid, then only channel 15
    for (int c = 0; c < NUM_CH; c++) memData[c] = 12'd5;
    thresh = 12'd100;
    memData[0] = 12'd700;
    runSeq(1'b1, 1, 1'b0);
    memData[0] = 12'd5; memData[15] = 12'hFFF;
    runSeq(1'b1, 1, 1'b0);
    // Every channel valid
    for (int c = 0; c < NUM_CH; c++) memData[c] = DATA_W'(c * 100 + 1);
    thresh = 12'd0;
    runSeq(1'b1, 0, 1'b0);
    // Starts injected during readout
    fillRandom(2500);
    runSeq(1'b1, 2, 1'b1);
    runSeq(1'b0, 1, 1'b1);
    // Random mix
    for (int t = 0; t < 20; t++) begin
      fillRandom($urandom_range(0, 4095));
      runSeq(1'($urandom_range(0, 1)), 3, 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule